// File: doc/BRIEF.md
# PWM Fault Guard

The block sits between a PWM waveform generator and the output pins. It watches four fault inputs and, while any of them is in its fault condition, replaces every PWM output with a safe value chosen per output: driven low, driven high, or released to high impedance. Each fault input can pass through a digital glitch filter, and it then feeds a sticky fault flag. The outputs return to normal only at a cycle boundary that the PWM counter marks with a half-cycle or a full-cycle strobe. Each input has its own rule for when that return is allowed.

Software sets the block up through a small register port. Writes take effect on the clock edge that samples them, and reads are combinational. Address 0 holds four 4-bit fields, one bit per input in each: bits [3:0] polarity (1 = the input is active low), bits [7:4] automatic clearing, bits [11:8] safety interlock for manual clearing, and bits [15:12] a switch that turns off the direct combinational disable path. Address 1 holds the recovery boundaries: bits [3:0] enable half-cycle recovery and bits [7:4] enable full-cycle recovery. Address 2 holds the filter settings: bits [7:0] the sample period, bits [10:8] the count, and bit 11 glitch stretch. Address 3 reads back the fault flags in bits [3:0] and the filtered fault states in bits [7:4]. Writing 1 to a bit in [3:0] of address 3 clears that flag. Address 4 holds the interrupt enables in bits [3:0].

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset all registers read 0 and the flags and irq are 0. While no fault is held and no raw fault is active, each pwm_out equals pwm_in and each pwm_oe is 1.
- R2: An input is active when it is 1 and its polarity bit is 0, or when it is 0 and its polarity bit is 1. The first cycle in which the filtered input becomes active sets its flag and its fault hold, even when neither recovery boundary is enabled for that input.
- R3: While any fault hold is set, output j is forced by fault_sel[2j+1:2j]: 00 drives 0, 01 drives 1, and 1x gives pwm_oe=0 with pwm_out=0. A hold is released only by a strobe that is enabled for its input. With no boundary enabled, the outputs stay forced.
- R4: With automatic clearing, an enabled strobe releases the hold once the filtered input is inactive, and the flag stays set. A strobe that is not enabled for the input has no effect.
- R5: With manual clearing, an enabled strobe releases the hold only after the flag has been cleared. This holds even if the input is still active.
- R6: With manual clearing and the safety bit set, release additionally requires the filtered input to be inactive.
- R7: With the combinational path on, a raw active input forces the outputs in the same cycle. With it off, the outputs are forced only from the clock edge after the filtered input becomes active.
- R8: Writing 1 to a flag bit at address 3 clears it. Writing 0 leaves it unchanged.
- R9: irq is 1 exactly when some flag is set and its enable bit at address 4 is set.
- R10: With a non-zero period P, the input is sampled every P clocks. A change passes the filter only after count+3 consecutive samples that differ from the filtered state. A period of 0 bypasses the filter.
- R11: A non-zero period write is ignored while the period is non-zero. Writing a period of 0 clears the filter state, so the filtered state then reads 0.
- R12: With the stretch bit set, a raw active pulse keeps the combinational disable asserted for two further clocks after it ends. With the bit clear, the disable ends with the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_in | input | 4 | Raw fault inputs |
| half_stb | input | 1 | Half-cycle boundary strobe from the PWM counter |
| full_stb | input | 1 | Full-cycle boundary strobe from the PWM counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pwm_in | input | 4 | PWM waveforms from the generator |
| fault_sel | input | 8 | Per-output safe-state select, 2 bits per output |
| pwm_out | output | 4 | Gated PWM outputs |
| pwm_oe | output | 4 | Output drive enables (0 = high impedance) |
| irq | output | 1 | Fault interrupt |

## Verification
The bench drives a fault on one input while that input's flag is still set, then clears the flag while the input stays active. This tells the manual rule apart from the safety rule: a design that mixed them up would either release unsafely or never release. It strobes a boundary that is not enabled for the input and checks that the outputs stay forced, which catches a design that releases on any strobe. It also sends fault pulses that cover fewer filter samples than the count needs, and expects them to vanish, while a sustained fault must get through within three sample periods. Finally it checks that a second non-zero period write is refused and that a zero write wipes a filtered state still sitting at 1. It also checks the two extra clocks of a stretched pulse, which would show up as an early or missing release.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NFLT = 4,
  parameter int NOUT = 4,
  parameter int PW   = 8,
  parameter int CW   = 3,
  localparam int DW  = 4 * NFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLT-1:0]   flt_in,
  input  logic              half_stb,
  input  logic              full_stb,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NOUT-1:0]   pwm_in,
  input  logic [2*NOUT-1:0] fault_sel,
  output logic [NOUT-1:0]   pwm_out,
  output logic [NOUT-1:0]   pwm_oe,
  output logic              irq
);
  localparam int SW = CW + 1;
  localparam logic [2:0] A_MODE = 3'd0, A_RECOV = 3'd1, A_FILT = 3'd2, A_FLAG = 3'd3, A_IEN = 3'd4;

  logic [NFLT-1:0] pol_q, auto_q, safe_q, coff_q, hen_q, fen_q, ien_q;
  logic [NFLT-1:0] flag_q, filt_q, filt_d, hold_q;
  logic [PW-1:0]   per_q, pcnt_q;
  logic [CW-1:0]   fcnt_q;
  logic            gstr_q;

  logic [NFLT-1:0] norm, filt, rise, clr, bnd, rel, str_act;
  logic            byp, tick, zero_wr, dis;

  assign norm    = flt_in ^ pol_q;
  assign byp     = (per_q == '0);
  assign tick    = !byp && (pcnt_q == per_q - 1'b1);
  assign zero_wr = wr_en && (wr_addr == A_FILT) && (wr_data[PW-1:0] == '0);
  assign filt    = byp ? norm : filt_q;
  assign rise    = filt & ~filt_d;
  assign clr     = (wr_en && wr_addr == A_FLAG) ? wr_data[NFLT-1:0] : '0;
  assign bnd     = ({NFLT{half_stb}} & hen_q) | ({NFLT{full_stb}} & fen_q);
  assign rel     = (auto_q & ~filt) | (~auto_q & ~flag_q & (~safe_q | ~filt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0; auto_q <= '0; safe_q <= '0; coff_q <= '0;
      hen_q <= '0; fen_q <= '0; ien_q <= '0;
      per_q <= '0; fcnt_q <= '0; gstr_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: {coff_q, safe_q, auto_q, pol_q} <= wr_data;
        A_RECOV: begin
          hen_q <= wr_data[NFLT-1:0];
          fen_q <= wr_data[2*NFLT-1:NFLT];
        end
        A_FILT: begin
          if (byp || zero_wr) per_q <= wr_data[PW-1:0];
          fcnt_q <= wr_data[PW +: CW];
          gstr_q <= wr_data[PW+CW];
        end
        A_IEN: ien_q <= wr_data[NFLT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pcnt_q <= '0;
    else if (byp || zero_wr || tick) pcnt_q <= '0;
    else                           pcnt_q <= pcnt_q + 1'b1;
  end

  for (genvar i = 0; i < NFLT; i++) begin : g_flt
    logic [SW-1:0] eq_q;
    logic [1:0]    str_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eq_q <= '0;
        filt_q[i] <= 1'b0;
      end else if (byp || zero_wr) begin
        eq_q <= '0;
        filt_q[i] <= 1'b0;
      end else if (tick) begin
        if (norm[i] == filt_q[i]) eq_q <= '0;
        else if (eq_q == SW'(fcnt_q) + SW'(2)) begin
          filt_q[i] <= norm[i];
          eq_q <= '0;
        end else eq_q <= eq_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           str_q <= '0;
      else if (norm[i])     str_q <= 2'd2;
      else if (str_q != '0) str_q <= str_q - 1'b1;
    end

    assign str_act[i] = norm[i] | (gstr_q & (str_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_d <= '0;
      flag_q <= '0;
      hold_q <= '0;
    end else begin
      filt_d <= filt;
      flag_q <= (flag_q & ~clr) | rise;
      hold_q <= rise | (hold_q & ~(bnd & rel));
    end
  end

  assign dis = (|hold_q) | (|(str_act & ~coff_q));
  assign irq = |(flag_q & ien_q);

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    assign pwm_oe[j]  = ~(dis & fault_sel[2*j+1]);
    assign pwm_out[j] = dis ? (~fault_sel[2*j+1] & fault_sel[2*j]) : pwm_in[j];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE:  rd_data = {coff_q, safe_q, auto_q, pol_q};
      A_RECOV: rd_data[2*NFLT-1:0] = {fen_q, hen_q};
      A_FILT:  rd_data[PW+CW:0] = {gstr_q, fcnt_q, per_q};
      A_FLAG:  rd_data[2*NFLT-1:0] = {filt, flag_q};
      A_IEN:   rd_data[NFLT-1:0] = ien_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
  parameter int NFLT = 4,
  parameter int PW   = 8,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            half_stb,
  input logic            full_stb,
  input logic [NFLT-1:0] hold,
  input logic [NFLT-1:0] flag,
  input logic [NFLT-1:0] rise,
  input logic [NFLT-1:0] filt,
  input logic [NFLT-1:0] safe,
  input logic [NFLT-1:0] autoc,
  input logic [PW-1:0]   per
);
  for (genvar i = 0; i < NFLT; i++) begin : g_a
    a_r3_hold_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      hold[i] && !half_stb && !full_stb |=> hold[i]);
    a_r2_flag_on_first_active: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> flag[i]);
    a_r8_flag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == 3'd3 && wr_data[i] && !rise[i] |=> !flag[i]);
    a_r6_safety_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold[i] && safe[i] && !autoc[i] && filt[i] |=> hold[i]);
  end

  a_r11_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd2 && per != '0 && wr_data[PW-1:0] != '0 |=> $stable(per));
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.NFLT(NFLT), .PW(PW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .half_stb(half_stb), .full_stb(full_stb), .hold(hold_q), .flag(flag_q),
  .rise(rise), .filt(filt), .safe(safe_q), .autoc(auto_q), .per(per_q)
);

// File: tb/pwm_fault_guard_tb.sv
module pwm_fault_guard_tb;
  localparam int NFLT = 4, NOUT = 4, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NFLT-1:0] flt_in = '0;
  logic half_stb = 1'b0, full_stb = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data, v;
  logic [NOUT-1:0] pwm_in = '0, pwm_out, pwm_oe;
  logic [2*NOUT-1:0] fault_sel = '0;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  pwm_fault_guard u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*NOUT-1:0] exp_pins(logic [NOUT-1:0] pin, logic [2*NOUT-1:0] sel, bit dis);
    logic [NOUT-1:0] o, e;
    for (int j = 0; j < NOUT; j++) begin
      e[j] = !(dis && sel[2*j+1]);
      o[j] = dis ? (!sel[2*j+1] && sel[2*j]) : pin[j];
    end
    return {e, o};
  endfunction

  task automatic chk_pins(string tag, bit dis);
    logic [2*NOUT-1:0] ex;
    ex = exp_pins(pwm_in, fault_sel, dis);
    check({pwm_oe, pwm_out} == ex, tag, {pwm_oe, pwm_out}, ex);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic strobe(bit full);
    if (full) full_stb = 1'b1; else half_stb = 1'b1;
    tick();
    half_stb = 1'b0; full_stb = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    pwm_in = 4'b1010; fault_sel = 8'b10_01_00_01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == '0, "R1 reset register", v, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    for (int k = 0; k < 60; k++) begin
      tick();
      pwm_in = 4'($urandom); fault_sel = 8'($urandom);
      #1 chk_pins("R1 pass-through", 1'b0);
    end

    fault_sel = 8'b10_01_00_01;
    wr(3'd1, 16'h0086);
    wr(3'd4, 16'h0008);
    wr(3'd0, 16'hF484);
    tick();
    rd(3'd3, v);
    check(v[2] == 1'b1, "R2 polarity flag", v, 16'h0004);
    chk_pins("R3 forced state", 1'b1);
    wr(3'd3, 16'h0004);
    strobe(1'b0);
    chk_pins("R6 safety keeps outputs forced", 1'b1);
    flt_in[2] = 1'b1;
    tick();
    strobe(1'b0);
    chk_pins("R6 safety release", 1'b0);

    flt_in[1] = 1'b1;
    #1 chk_pins("R7 no combinational path", 1'b0);
    tick();
    chk_pins("R7 latched disable", 1'b1);
    rd(3'd3, v);
    check(v[1] == 1'b1, "R2 flag set", v[1], 1);
    strobe(1'b0);
    chk_pins("R5 flag still set", 1'b1);
    wr(3'd3, 16'h0002);
    rd(3'd3, v);
    check(v[1] == 1'b0, "R8 w1c", v[1], 0);
    strobe(1'b0);
    chk_pins("R5 manual release while active", 1'b0);
    flt_in[1] = 1'b0;
    tick();

    flt_in[3] = 1'b1;
    tick();
    chk_pins("R3 forced by input 3", 1'b1);
    check(irq == 1'b1, "R9 irq enabled flag", irq, 1);
    flt_in[3] = 1'b0;
    tick();
    chk_pins("R4 no boundary yet", 1'b1);
    strobe(1'b0);
    chk_pins("R4 disabled boundary ignored", 1'b1);
    strobe(1'b1);
    chk_pins("R4 auto release", 1'b0);
    rd(3'd3, v);
    check(v[3] == 1'b1, "R4 flag persists", v[3], 1);
    check(irq == 1'b1, "R9 irq persists", irq, 1);
    wr(3'd3, 16'h0008);
    check(irq == 1'b0, "R9 irq cleared", irq, 0);

    wr(3'd0, 16'hE484);
    flt_in[0] = 1'b1;
    #1 chk_pins("R7 combinational disable", 1'b1);
    check(irq == 1'b0, "R9 masked flag", irq, 0);
    tick();
    flt_in[0] = 1'b0;
    tick();
    strobe(1'b0);
    strobe(1'b1);
    chk_pins("R3 no recovery boundary", 1'b1);
    rd(3'd3, v);
    check(v[0] == 1'b1, "R2 flag with no recovery", v[0], 1);
    for (int k = 0; k < 100; k++) begin
      tick();
      pwm_in = 4'($urandom); fault_sel = 8'($urandom);
      #1 chk_pins("R3 random forced state", 1'b1);
    end
    wr(3'd1, 16'h0087);
    wr(3'd3, 16'h0001);
    strobe(1'b0);
    chk_pins("R3 release once enabled", 1'b0);

    wr(3'd2, 16'h0004);
    flt_in[1] = 1'b1;
    repeat (6) tick();
    flt_in[1] = 1'b0;
    repeat (2) tick();
    chk_pins("R10 short pulse rejected", 1'b0);
    rd(3'd3, v);
    check(v[1] == 1'b0, "R10 no flag from short pulse", v[1], 0);
    repeat (10) tick();
    flt_in[1] = 1'b1;
    repeat (7) tick();
    chk_pins("R10 not passed early", 1'b0);
    repeat (7) tick();
    chk_pins("R10 passed after samples", 1'b1);
    rd(3'd3, v);
    check(v[5] == 1'b1, "R10 filtered state", v[5], 1);

    rd(3'd2, v);
    check(v == 16'h0004, "R11 period", v, 16'h0004);
    wr(3'd2, 16'h0009);
    rd(3'd2, v);
    check(v == 16'h0004, "R11 locked period", v, 16'h0004);
    flt_in[1] = 1'b0;
    wr(3'd2, 16'h0000);
    wr(3'd2, 16'h00C8);
    rd(3'd3, v);
    check(v[5] == 1'b0, "R11 zero write clears filter", v[5], 0);
    rd(3'd2, v);
    check(v == 16'h00C8, "R11 new period", v, 16'h00C8);
    wr(3'd3, 16'h0002);
    strobe(1'b0);
    chk_pins("R5 release after filter test", 1'b0);

    wr(3'd2, 16'h0000);
    wr(3'd2, 16'h07C8);
    flt_in[0] = 1'b1;
    tick();
    flt_in[0] = 1'b0;
    #1 chk_pins("R12 no stretch", 1'b0);
    wr(3'd2, 16'h0000);
    wr(3'd2, 16'h0FC8);
    flt_in[0] = 1'b1;
    tick();
    flt_in[0] = 1'b0;
    #1 chk_pins("R12 stretch clock 0", 1'b1);
    tick();
    chk_pins("R12 stretch clock 1", 1'b1);
    tick();
    chk_pins("R12 stretch ends", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule